// File: doc/BRIEF.md
# Send-DMA Engine Lifecycle Controller

This block sequences a send-DMA engine through its life: powered down, waiting for start-up, idle, running, waiting for a halt, and the two clean-up waits (hardware first, then software). Other logic reports what happened as one-cycle event pulses. The controller answers with a registered per-state control word (enable, interrupt enable, halt, drain) and with one-cycle requests that tell the surrounding logic to start software clean-up, start hardware clean-up, disarm buffers and restart the engine, or release the engine. The clean-up and start-up work itself is done elsewhere. The controller only issues the requests and waits for the matching completion event.

A latched run-intent flag records whether software wants the engine running. Go-running and go-idle events update the flag while a clean-up or start-up is in progress. When start-up completes, the flag decides between idle and running. The state, the flag, the last accepted event and the state before the most recent transition are visible at the ports.

All pins are plain level or pulse signals. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. An event that has no meaning in the current state is simply dropped.

Top module: `dma_life_ctl`

## Requirements
- R1: While rst_n is low and after it rises, state_o is 0 (down), ctrl_o is 0, run_intent_o is 0, all four request outputs are 0, last_evt_o is 15 (none) and prev_state_o is 0.
- R2: Events arrive as one-cycle pulses on evt_i with these bit positions: 0 go-down, 1 go-start, 2 started, 3 go-running, 4 software-cleaned, 5 hardware-cleaned, 6 halted, 7 go-idle, 8 error-halt A, 9 error-halt B, 10 timer tick. When several bits are high in one cycle, only the lowest-numbered one is accepted and the others are dropped.
- R3: State codes are down 0, start-up-wait 1, idle 2, software-clean-wait 3, hardware-clean-wait 4, halt-wait 5, running 6. In down, go-start moves to start-up-wait. Go-running also moves to start-up-wait and sets the run intent. Software-cleaned pulses the release request without leaving down.
- R4: In start-up-wait, started moves to running if the run intent is set and to idle otherwise. Go-running sets the intent and go-idle clears it, and neither changes the state.
- R5: In idle, go-running moves to running and sets the intent. In running, go-idle moves to halt-wait and clears the intent.
- R6: Halted in halt-wait moves to hardware-clean-wait and pulses the hardware clean-up request. Hardware-cleaned there moves to software-clean-wait and pulses the software clean-up request. Software-cleaned there moves to start-up-wait and pulses the disarm-and-start-up request.
- R7: In running, halted or error-halt A moves to software-clean-wait and pulses the software clean-up request. Error-halt B moves to halt-wait and issues no request.
- R8: Go-down moves to down from every other state. From running, halt-wait or hardware-clean-wait it also pulses the software clean-up request. From start-up-wait or idle it pulses release. From software-clean-wait it issues no request. Go-down leaves the run intent unchanged.
- R9: In the three clean-up and halt waits, go-running sets the intent and go-idle clears it. The timer tick, and every event with no listed action in the current state, changes neither the state, the intent nor any output except last_evt_o.
- R10: ctrl_o (bit 0 enable, bit 1 interrupt enable, bit 2 halt, bit 3 drain) takes its new value in the same clock edge as the state. The values per state are: running 0011, idle 0010, halt-wait 0100, software-clean-wait 0100, hardware-clean-wait 1100, down and start-up-wait 0000.
- R11: Each request output is high for exactly the one cycle after the accepting edge, and at most one request is high at a time.
- R12: last_evt_o holds the bit number of the most recently accepted event, including an ignored one. prev_state_o takes the old state code whenever the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 11 | One-cycle event pulses, bit positions per R2 |
| state_o | output | 3 | Current state code |
| ctrl_o | output | 4 | Engine control word: drain, halt, interrupt enable, enable (MSB to LSB) |
| run_intent_o | output | 1 | Latched run intent |
| req_sw_clean_o | output | 1 | Start software clean-up (one cycle) |
| req_hw_clean_o | output | 1 | Start hardware clean-up (one cycle) |
| req_startup_o | output | 1 | Disarm buffers and start up the engine (one cycle) |
| req_release_o | output | 1 | Release the engine (one cycle) |
| last_evt_o | output | 4 | Last accepted event number, 15 when none |
| prev_state_o | output | 3 | State before the latest transition |

## Verification
Two event pulses can arrive in the same cycle, for example go-down together with go-start or started, or halted together with go-idle and a tick. The arbitration order then decides which transition and which request take effect. The bench sweeps every state against every single event, then drives such multi-bit masks on purpose. It judges the result against a table model that applies only the lowest-numbered bit. A request from one event and the next event also share an edge. The bench checks that the request drops in the following cycle unless the new event issues one of its own.

// File: rtl/dle_pkg.sv
package dle_pkg;
  localparam int EVT_N = 11;
  localparam int EVT_W = $clog2(EVT_N + 1);
  localparam int ST_W  = 3;

  typedef enum logic [ST_W-1:0] {
    ST_DOWN  = 3'd0,
    ST_START = 3'd1,
    ST_IDLE  = 3'd2,
    ST_SWCLN = 3'd3,
    ST_HWCLN = 3'd4,
    ST_HALTW = 3'd5,
    ST_RUN   = 3'd6
  } life_state_e;

  localparam logic [EVT_W-1:0] EV_DOWN    = 4'd0;
  localparam logic [EVT_W-1:0] EV_START   = 4'd1;
  localparam logic [EVT_W-1:0] EV_STARTED = 4'd2;
  localparam logic [EVT_W-1:0] EV_GORUN   = 4'd3;
  localparam logic [EVT_W-1:0] EV_SWDONE  = 4'd4;
  localparam logic [EVT_W-1:0] EV_HWDONE  = 4'd5;
  localparam logic [EVT_W-1:0] EV_HALTED  = 4'd6;
  localparam logic [EVT_W-1:0] EV_GOIDLE  = 4'd7;
  localparam logic [EVT_W-1:0] EV_ERRA    = 4'd8;
  localparam logic [EVT_W-1:0] EV_ERRB    = 4'd9;
  localparam logic [EVT_W-1:0] EV_TICK    = 4'd10;
  localparam logic [EVT_W-1:0] EV_NONE    = {EVT_W{1'b1}};

  typedef struct packed {
    logic drain;
    logic halt;
    logic irq_en;
    logic en;
  } ctrl_t;

  typedef struct packed {
    logic rel;
    logic startup;
    logic hw_clean;
    logic sw_clean;
  } req_t;
endpackage

// File: rtl/dle_evt_arb.sv
module dle_evt_arb #(
  parameter int N = dle_pkg::EVT_N,
  parameter int W = dle_pkg::EVT_W
) (
  input  logic [N-1:0] pulse_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  logic [N-1:0] grant;

  // the lowest-numbered pulse wins; every higher bit is masked
  assign grant[0] = pulse_i[0];
  for (genvar g = 1; g < N; g++) begin : g_mask
    assign grant[g] = pulse_i[g] & ~(|pulse_i[g-1:0]);
  end

  assign hit_o = |grant;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/dle_xfer.sv
module dle_xfer
  import dle_pkg::*;
(
  input  life_state_e      cur_i,
  input  logic             intent_i,
  input  logic             hit_i,
  input  logic [EVT_W-1:0] idx_i,
  output life_state_e      nxt_o,
  output logic             intent_o,
  output req_t             req_o
);
  always_comb begin
    nxt_o    = cur_i;
    intent_o = intent_i;
    req_o    = '0;
    if (hit_i) begin
      unique case (cur_i)
        ST_DOWN: begin
          if (idx_i == EV_GORUN) begin
            intent_o = 1'b1;
            nxt_o    = ST_START;
          end else if (idx_i == EV_START) begin
            nxt_o = ST_START;
          end else if (idx_i == EV_SWDONE) begin
            req_o.rel = 1'b1;
          end
        end
        ST_START: begin
          if (idx_i == EV_DOWN) begin
            nxt_o     = ST_DOWN;
            req_o.rel = 1'b1;
          end else if (idx_i == EV_STARTED) begin
            nxt_o = intent_i ? ST_RUN : ST_IDLE;
          end else if (idx_i == EV_GORUN) begin
            intent_o = 1'b1;
          end else if (idx_i == EV_GOIDLE) begin
            intent_o = 1'b0;
          end
        end
        ST_IDLE: begin
          if (idx_i == EV_DOWN) begin
            nxt_o     = ST_DOWN;
            req_o.rel = 1'b1;
          end else if (idx_i == EV_GORUN) begin
            nxt_o    = ST_RUN;
            intent_o = 1'b1;
          end
        end
        ST_SWCLN: begin
          if (idx_i == EV_DOWN) begin
            nxt_o = ST_DOWN;
          end else if (idx_i == EV_SWDONE) begin
            nxt_o         = ST_START;
            req_o.startup = 1'b1;
          end else if (idx_i == EV_GORUN) begin
            intent_o = 1'b1;
          end else if (idx_i == EV_GOIDLE) begin
            intent_o = 1'b0;
          end
        end
        ST_HWCLN: begin
          if (idx_i == EV_DOWN) begin
            nxt_o          = ST_DOWN;
            req_o.sw_clean = 1'b1;
          end else if (idx_i == EV_HWDONE) begin
            nxt_o          = ST_SWCLN;
            req_o.sw_clean = 1'b1;
          end else if (idx_i == EV_GORUN) begin
            intent_o = 1'b1;
          end else if (idx_i == EV_GOIDLE) begin
            intent_o = 1'b0;
          end
        end
        ST_HALTW: begin
          if (idx_i == EV_DOWN) begin
            nxt_o          = ST_DOWN;
            req_o.sw_clean = 1'b1;
          end else if (idx_i == EV_HALTED) begin
            nxt_o          = ST_HWCLN;
            req_o.hw_clean = 1'b1;
          end else if (idx_i == EV_GORUN) begin
            intent_o = 1'b1;
          end else if (idx_i == EV_GOIDLE) begin
            intent_o = 1'b0;
          end
        end
        ST_RUN: begin
          if (idx_i == EV_DOWN) begin
            nxt_o          = ST_DOWN;
            req_o.sw_clean = 1'b1;
          end else if (idx_i == EV_HALTED || idx_i == EV_ERRA) begin
            nxt_o          = ST_SWCLN;
            req_o.sw_clean = 1'b1;
          end else if (idx_i == EV_GOIDLE) begin
            nxt_o    = ST_HALTW;
            intent_o = 1'b0;
          end else if (idx_i == EV_ERRB) begin
            nxt_o = ST_HALTW;
          end
        end
        default: nxt_o = ST_DOWN;
      endcase
    end
  end
endmodule

// File: rtl/dle_ctrl_map.sv
module dle_ctrl_map
  import dle_pkg::*;
(
  input  life_state_e st_i,
  output ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (st_i)
      ST_RUN: begin
        ctrl_o.en     = 1'b1;
        ctrl_o.irq_en = 1'b1;
      end
      ST_IDLE:  ctrl_o.irq_en = 1'b1;
      ST_HALTW: ctrl_o.halt   = 1'b1;
      ST_SWCLN: ctrl_o.halt   = 1'b1;
      ST_HWCLN: begin
        ctrl_o.halt  = 1'b1;
        ctrl_o.drain = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/dma_life_ctl.sv
module dma_life_ctl
  import dle_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_i,
  output logic [ST_W-1:0]  state_o,
  output logic [3:0]       ctrl_o,
  output logic             run_intent_o,
  output logic             req_sw_clean_o,
  output logic             req_hw_clean_o,
  output logic             req_startup_o,
  output logic             req_release_o,
  output logic [EVT_W-1:0] last_evt_o,
  output logic [ST_W-1:0]  prev_state_o
);
  logic             hit;
  logic [EVT_W-1:0] idx;
  life_state_e      state_q, prev_q, nxt;
  logic             intent_q, intent_d;
  req_t             req_d, req_q;
  ctrl_t            ctrl_d, ctrl_q;
  logic [EVT_W-1:0] last_q;

  dle_evt_arb #(.N(EVT_N), .W(EVT_W)) u_arb (
    .pulse_i (evt_i),
    .hit_o   (hit),
    .idx_o   (idx)
  );

  dle_xfer u_xfer (
    .cur_i    (state_q),
    .intent_i (intent_q),
    .hit_i    (hit),
    .idx_i    (idx),
    .nxt_o    (nxt),
    .intent_o (intent_d),
    .req_o    (req_d)
  );

  // control word looks at the next state so it lands with the state
  dle_ctrl_map u_map (
    .st_i   (nxt),
    .ctrl_o (ctrl_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_DOWN;
      prev_q   <= ST_DOWN;
      intent_q <= 1'b0;
      req_q    <= '0;
      ctrl_q   <= '0;
      last_q   <= EV_NONE;
    end else begin
      state_q  <= nxt;
      intent_q <= intent_d;
      req_q    <= req_d;
      ctrl_q   <= ctrl_d;
      if (hit) last_q <= idx;
      if (nxt != state_q) prev_q <= state_q;
    end
  end

  assign state_o        = state_q;
  assign prev_state_o   = prev_q;
  assign ctrl_o         = ctrl_q;
  assign run_intent_o   = intent_q;
  assign req_sw_clean_o = req_q.sw_clean;
  assign req_hw_clean_o = req_q.hw_clean;
  assign req_startup_o  = req_q.startup;
  assign req_release_o  = req_q.rel;
  assign last_evt_o     = last_q;

  // R11
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_q));

  // R10
  en_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |-> (state_q == ST_RUN));

  // R6
  hw_req_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q.hw_clean |-> (state_q == ST_HWCLN));

  // R4
  start_to_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && hit && idx == EV_STARTED && intent_q)
      |=> (state_q == ST_RUN));

  // R8
  go_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && idx == EV_DOWN) |=> (state_q == ST_DOWN));

  // R9
  tick_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && idx == EV_TICK) |=> ($stable(state_q) && $stable(intent_q)));
endmodule

// File: tb/dma_life_ctl_tb.sv
`timescale 1ns/1ps
module dma_life_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] evt = '0;
  logic [2:0]  state_o, prev_state_o;
  logic [3:0]  ctrl_o, last_evt_o;
  logic        run_intent_o, req_sw, req_hw, req_su, req_rel;

  int n_chk = 0;
  int n_fail = 0;

  // model state
  logic [2:0] ms, mprev;
  logic       mi;
  logic [3:0] mlast;

  always #4 clk = ~clk;

  dma_life_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt),
    .state_o(state_o), .ctrl_o(ctrl_o), .run_intent_o(run_intent_o),
    .req_sw_clean_o(req_sw), .req_hw_clean_o(req_hw),
    .req_startup_o(req_su), .req_release_o(req_rel),
    .last_evt_o(last_evt_o), .prev_state_o(prev_state_o)
  );

  task automatic check(input logic ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [3:0] ctrl_exp(input logic [2:0] s);
    case (s)
      3'd6: return 4'b0011;
      3'd2: return 4'b0010;
      3'd5: return 4'b0100;
      3'd3: return 4'b0100;
      3'd4: return 4'b1100;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic int low_bit(input logic [10:0] m);
    for (int i = 10; i >= 0; i--) if (m[i]) low_bit = i;
    if (m == 0) low_bit = -1;
  endfunction

  // returns {next state, intent, req {rel,startup,hw,sw}}
  function automatic logic [7:0] model(input logic [2:0] s, input logic it,
                                       input logic [10:0] m);
    logic [2:0] n = s;
    logic       ni = it;
    logic [3:0] r = 4'b0;
    int e = low_bit(m);
    case (s)
      3'd0: if (e == 3) begin n = 1; ni = 1; end
            else if (e == 1) n = 1;
            else if (e == 4) r = 4'b1000;
      3'd1: if (e == 0) begin n = 0; r = 4'b1000; end
            else if (e == 2) n = it ? 3'd6 : 3'd2;
            else if (e == 3) ni = 1;
            else if (e == 7) ni = 0;
      3'd2: if (e == 0) begin n = 0; r = 4'b1000; end
            else if (e == 3) begin n = 6; ni = 1; end
      3'd3: if (e == 0) n = 0;
            else if (e == 4) begin n = 1; r = 4'b0100; end
            else if (e == 3) ni = 1;
            else if (e == 7) ni = 0;
      3'd4: if (e == 0) begin n = 0; r = 4'b0001; end
            else if (e == 5) begin n = 3; r = 4'b0001; end
            else if (e == 3) ni = 1;
            else if (e == 7) ni = 0;
      3'd5: if (e == 0) begin n = 0; r = 4'b0001; end
            else if (e == 6) begin n = 4; r = 4'b0010; end
            else if (e == 3) ni = 1;
            else if (e == 7) ni = 0;
      3'd6: if (e == 0) begin n = 0; r = 4'b0001; end
            else if (e == 6 || e == 8) begin n = 3; r = 4'b0001; end
            else if (e == 7) begin n = 5; ni = 0; end
            else if (e == 9) n = 5;
      default: n = 0;
    endcase
    return {n, ni, r};
  endfunction

  function automatic string tag_for(input logic [2:0] s, input int e);
    if (e == 0) return "R8";
    if (e == 10) return "R9";
    case (s)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd6: return (e == 7) ? "R5" : "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic compare(input string tag);
    check(state_o == ms, tag, "state", state_o, ms);
    check(run_intent_o == mi, tag, "intent", run_intent_o, mi);
    check(ctrl_o == ctrl_exp(ms), "R10", "ctrl", ctrl_o, ctrl_exp(ms));
    check(last_evt_o == mlast, "R12", "last_evt", last_evt_o, mlast);
    check(prev_state_o == mprev, "R12", "prev_state", prev_state_o, mprev);
  endtask

  task automatic apply(input logic [10:0] m, input string tag);
    logic [7:0] x;
    x = model(ms, mi, m);
    evt = m;
    @(posedge clk);
    @(negedge clk);
    evt = '0;
    if (m != 0) mlast = 4'(low_bit(m));
    if (x[7:5] != ms) mprev = ms;
    ms = x[7:5];
    mi = x[4];
    compare(tag);
    check({req_rel, req_su, req_hw, req_sw} == x[3:0], "R11", tag,
          {req_rel, req_su, req_hw, req_sw}, x[3:0]);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    evt = '0;
    repeat (2) @(negedge clk);
    ms = 0; mi = 0; mprev = 0; mlast = 4'hF;
    check(state_o == 0 && ctrl_o == 0 && run_intent_o == 0, "R1", "in reset",
          {state_o, ctrl_o, run_intent_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    check({req_rel, req_su, req_hw, req_sw} == 0, "R1", "requests",
          {req_rel, req_su, req_hw, req_sw}, 0);
  endtask

  task automatic go_to(input int s);
    case (s)
      1: apply(11'h002, "R3");
      2: begin apply(11'h002, "R3"); apply(11'h004, "R4"); end
      6: begin apply(11'h008, "R3"); apply(11'h004, "R4"); end
      5: begin apply(11'h008, "R3"); apply(11'h004, "R4");
               apply(11'h080, "R5"); end
      4: begin go_to(5); apply(11'h040, "R6"); end
      3: begin go_to(4); apply(11'h020, "R6"); end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // sweep every state against every single event
    for (int s = 0; s < 7; s++) begin
      for (int e = 0; e < 11; e++) begin
        do_reset();
        go_to(s);
        apply(11'(1) << e, tag_for(3'(s), e));
        apply('0, "R11");
      end
    end
    // intent changed during clean-up decides the restart (R4, R6, R9)
    do_reset();
    go_to(5);
    apply(11'h008, "R9");
    apply(11'h040, "R6");
    apply(11'h080, "R9");
    apply(11'h008, "R9");
    apply(11'h020, "R6");
    apply(11'h010, "R6");
    apply(11'h004, "R4");
    // start-up with intent cleared ends in idle
    do_reset();
    apply(11'h008, "R3");
    apply(11'h080, "R4");
    apply(11'h004, "R4");
    // simultaneous pulses: lowest bit wins (R2)
    do_reset();
    go_to(1);
    apply(11'h007, "R2");
    do_reset();
    go_to(5);
    apply(11'h4C0, "R2");
    do_reset();
    go_to(6);
    apply(11'h300, "R2");
    apply('0, "R2");
    do_reset();
    go_to(2);
    apply(11'h408, "R2");
    // back-to-back requests on consecutive edges (R11)
    do_reset();
    go_to(4);
    apply(11'h020, "R11");
    apply(11'h010, "R11");
    apply('0, "R11");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule